// File: doc/BRIEF.md
# Vector Length Configuration Registers

This block holds the four values that describe how a vector operation is shaped: the maximum vector length, the active vector length, and a starting element offset for each of the source and destination operands. Software reaches them through three register addresses: one for the maximum length alone, one for the active length alone, and one combined view that carries all four values in a single word.

Every write is range-limited on its way into storage. The maximum length never exceeds a fixed cap. The active length never exceeds the maximum length. An offset set through the combined view never reaches past the last active element. The combined view encodes both lengths as "value minus one", so a 5-bit field can express lengths from 1 to 32. A write of zero to either direct length address is flagged for one cycle. The stored value is still the clamped result of that write.

Writes take effect at the clock edge. Reads are combinational from the read address.

Top module: `vlcfg_regs`

## Requirements
- R1: A write to the maximum-length address (0x4C0) stores the smaller of the written value and 64. Reading that address returns the stored value, zero-extended to 64 bits.
- R2: A write to the active-length address (0x4C1) stores the smaller of the written value and the maximum length held before the write. Reading that address returns the stored value, zero-extended.
- R3: A write to the combined address (0x4C2) takes these fields from the write data: new maximum length = bits [4:0] + 1, and new active length = the smaller of (bits [10:6] + 1) and the new maximum length. All other bits are ignored.
- R4: The same combined write sets the source offset to the smaller of bits [16:12] and (new active length − 1). It sets the destination offset to the smaller of bits [22:18] and (new active length − 1).
- R5: Reading the combined address returns the following fields, each 6 bits wide. Every other bit reads as zero.
  - [5:0]: active length − 1
  - [11:6]: maximum length − 1
  - [17:12]: source offset
  - [23:18]: destination offset
- R6: Writes to the maximum-length or active-length address leave both offsets unchanged. A write to the maximum-length address also leaves the active length unchanged.
- R7: A synchronous active-high reset sets both lengths to 1 and both offsets to 0, and clears the error flag.
- R8: A write of zero to the maximum-length or active-length address drives the error flag high for exactly the next cycle. The zero is still stored as the clamped result. Any other write leaves the flag low in the next cycle.
- R9: With the write enable low, or with a write to any other address, nothing changes. Reading an address other than the three returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 12 | Read address |
| rd_data | output | 64 | Combinational read data |
| len_err | output | 1 | One-cycle flag after a zero write to a direct length address |

## Verification
The bench covers each clamping boundary:
- Maximum-length writes above 64 must saturate. A design that truncates the value instead would read back a small, wrong length.
- An active-length write must clamp against the maximum held before the write, not against the written value.
- A combined write must clamp offsets against the new active length. A design that compares against the old active length leaves offsets beyond the last element.

The bench also writes the maximum length below the current active length, and checks that neither the active length nor the offsets move. It checks that the gap bits of the combined write are ignored. It checks that the error flag pulses for exactly one cycle and only on zero writes to the direct addresses, never on a combined write of all zeros.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    // Which of the three registers an address selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MAX  = 2'd1,
        SEL_ACT  = 2'd2,
        SEL_PACK = 2'd3
    } vsel_e;

    localparam int unsigned CMP_W = 8;

    // Unsigned minimum over a small fixed width
    function automatic logic [CMP_W-1:0] umin8(input logic [CMP_W-1:0] a,
                                               input logic [CMP_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
    import vlcfg_pkg::*;
#(
    parameter int unsigned    ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] A_MAX  = 12'h4C0,
    parameter logic [ADDR_W-1:0] A_ACT  = 12'h4C1,
    parameter logic [ADDR_W-1:0] A_PACK = 12'h4C2
) (
    input  logic [ADDR_W-1:0] addr,
    output vsel_e             sel
);
    always_comb begin
        unique case (addr)
            A_MAX:   sel = SEL_MAX;
            A_ACT:   sel = SEL_ACT;
            A_PACK:  sel = SEL_PACK;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/vlcfg_next.sv
module vlcfg_next
    import vlcfg_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned LEN_W     = 7,
    parameter int unsigned OFF_W     = 6,
    parameter int unsigned MAX_LIMIT = 64,
    parameter int unsigned FIELD_W   = 5,
    parameter int unsigned STRIDE    = 6
) (
    input  logic             we,
    input  vsel_e            sel,
    input  logic [XLEN-1:0]  wdata,
    input  logic [LEN_W-1:0] cur_max,
    input  logic [LEN_W-1:0] cur_act,
    input  logic [OFF_W-1:0] cur_src,
    input  logic [OFF_W-1:0] cur_dst,
    output logic [LEN_W-1:0] nxt_max,
    output logic [LEN_W-1:0] nxt_act,
    output logic [OFF_W-1:0] nxt_src,
    output logic [OFF_W-1:0] nxt_dst,
    output logic             zero_hit
);
    localparam int unsigned NFLD = 4;
    localparam logic [LEN_W-1:0] LIMIT_L = LEN_W'(MAX_LIMIT);

    logic [FIELD_W-1:0] fld [NFLD];
    logic [LEN_W-1:0]   p_max, p_act_req, p_act, p_last;
    logic [LEN_W-1:0]   d_max, d_act;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        assign fld[g] = wdata[g*STRIDE +: FIELD_W];
    end

    always_comb begin
        // direct writes: saturate in the full data width
        d_max = (wdata > XLEN'(MAX_LIMIT)) ? LIMIT_L : wdata[LEN_W-1:0];
        d_act = (wdata > XLEN'(cur_max))   ? cur_max : wdata[LEN_W-1:0];

        // combined write: max first, then active against new max, then offsets
        p_max     = LEN_W'(fld[0]) + LEN_W'(1);
        if (p_max > LIMIT_L) p_max = LIMIT_L;
        p_act_req = LEN_W'(fld[1]) + LEN_W'(1);
        p_act     = LEN_W'(umin8(CMP_W'(p_max), CMP_W'(p_act_req)));
        p_last    = p_act - LEN_W'(1);

        nxt_max = cur_max;
        nxt_act = cur_act;
        nxt_src = cur_src;
        nxt_dst = cur_dst;
        if (we) begin
            unique case (sel)
                SEL_MAX: nxt_max = d_max;
                SEL_ACT: nxt_act = d_act;
                SEL_PACK: begin
                    nxt_max = p_max;
                    nxt_act = p_act;
                    nxt_src = OFF_W'(umin8(CMP_W'(fld[2]), CMP_W'(p_last)));
                    nxt_dst = OFF_W'(umin8(CMP_W'(fld[3]), CMP_W'(p_last)));
                end
                default: ;
            endcase
        end
        zero_hit = we && (sel == SEL_MAX || sel == SEL_ACT) && (wdata == '0);
    end
endmodule

// File: rtl/vlcfg_rdmux.sv
module vlcfg_rdmux
    import vlcfg_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned LEN_W  = 7,
    parameter int unsigned OFF_W  = 6,
    parameter int unsigned STRIDE = 6
) (
    input  vsel_e            sel,
    input  logic [LEN_W-1:0] cur_max,
    input  logic [LEN_W-1:0] cur_act,
    input  logic [OFF_W-1:0] cur_src,
    input  logic [OFF_W-1:0] cur_dst,
    output logic [XLEN-1:0]  rdata
);
    logic [LEN_W-1:0] act_m1, max_m1;

    always_comb begin
        act_m1 = cur_act - LEN_W'(1);
        max_m1 = cur_max - LEN_W'(1);
        rdata  = '0;
        unique case (sel)
            SEL_MAX: rdata = XLEN'(cur_max);
            SEL_ACT: rdata = XLEN'(cur_act);
            SEL_PACK: begin
                rdata[0*STRIDE +: STRIDE] = STRIDE'(act_m1);
                rdata[1*STRIDE +: STRIDE] = STRIDE'(max_m1);
                rdata[2*STRIDE +: STRIDE] = STRIDE'(cur_src);
                rdata[3*STRIDE +: STRIDE] = STRIDE'(cur_dst);
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/vlcfg_regs.sv
module vlcfg_regs
    import vlcfg_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MAX_LIMIT = 64,
    parameter int unsigned FIELD_W   = 5,
    parameter int unsigned STRIDE    = 6,
    parameter logic [ADDR_W-1:0] A_MAX  = 12'h4C0,
    parameter logic [ADDR_W-1:0] A_ACT  = 12'h4C1,
    parameter logic [ADDR_W-1:0] A_PACK = 12'h4C2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [XLEN-1:0]   rd_data,
    output logic              len_err
);
    localparam int unsigned LEN_W = $clog2(MAX_LIMIT + 1);
    localparam int unsigned OFF_W = $clog2(MAX_LIMIT);

    vsel_e            wsel, rsel;
    logic [LEN_W-1:0] max_q, act_q, max_d, act_d;
    logic [OFF_W-1:0] src_q, dst_q, src_d, dst_d;
    logic             zero_hit, err_q;

    vlcfg_decode #(.ADDR_W(ADDR_W), .A_MAX(A_MAX), .A_ACT(A_ACT), .A_PACK(A_PACK))
        u_wdec (.addr(wr_addr), .sel(wsel));
    vlcfg_decode #(.ADDR_W(ADDR_W), .A_MAX(A_MAX), .A_ACT(A_ACT), .A_PACK(A_PACK))
        u_rdec (.addr(rd_addr), .sel(rsel));

    vlcfg_next #(.XLEN(XLEN), .LEN_W(LEN_W), .OFF_W(OFF_W), .MAX_LIMIT(MAX_LIMIT),
                 .FIELD_W(FIELD_W), .STRIDE(STRIDE))
        u_next (.we(wr_en), .sel(wsel), .wdata(wr_data),
                .cur_max(max_q), .cur_act(act_q), .cur_src(src_q), .cur_dst(dst_q),
                .nxt_max(max_d), .nxt_act(act_d), .nxt_src(src_d), .nxt_dst(dst_d),
                .zero_hit(zero_hit));

    vlcfg_rdmux #(.XLEN(XLEN), .LEN_W(LEN_W), .OFF_W(OFF_W), .STRIDE(STRIDE))
        u_rd (.sel(rsel), .cur_max(max_q), .cur_act(act_q), .cur_src(src_q),
              .cur_dst(dst_q), .rdata(rd_data));

    always_ff @(posedge clk) begin
        if (rst) begin
            max_q <= LEN_W'(1);
            act_q <= LEN_W'(1);
            src_q <= '0;
            dst_q <= '0;
            err_q <= 1'b0;
        end else begin
            max_q <= max_d;
            act_q <= act_d;
            src_q <= src_d;
            dst_q <= dst_d;
            err_q <= zero_hit;
        end
    end

    assign len_err = err_q;

    // R1: stored maximum never exceeds the cap
    p_max_cap_r1: assert property (@(posedge clk) disable iff (rst)
        max_q <= LEN_W'(MAX_LIMIT));

    // R2: a direct active-length write never exceeds the prior maximum
    p_act_clamp_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == SEL_ACT) |=> (act_q <= $past(max_q)));

    // R4: offsets land inside the new active length after a combined write
    p_off_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == SEL_PACK) |=> (LEN_W'(src_q) < act_q && LEN_W'(dst_q) < act_q));

    // R6: direct length writes keep both offsets
    p_off_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wsel == SEL_MAX || wsel == SEL_ACT)) |=> ($stable(src_q) && $stable(dst_q)));

    // R8: zero write to a direct length raises the flag next cycle
    p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wsel == SEL_MAX || wsel == SEL_ACT) && wr_data == '0) |=> len_err);

    // R8: no zero direct write means no flag next cycle
    p_err_clr_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wsel == SEL_MAX || wsel == SEL_ACT) && wr_data == '0) |=> !len_err);

    // R9: idle cycles change no state
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wsel == SEL_NONE) |=> $stable({max_q, act_q, src_q, dst_q}));
endmodule

// File: tb/vlcfg_regs_test.sv
`timescale 1ns/1ps
module vlcfg_regs_test;
    localparam logic [11:0] AM = 12'h4C0;
    localparam logic [11:0] AV = 12'h4C1;
    localparam logic [11:0] AP = 12'h4C2;

    typedef struct packed {
        logic        we;
        logic [11:0] waddr;
        logic [63:0] wdata;
        logic [11:0] raddr;
        logic [63:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, AM, 64'd40,          AM, 64'd40,       4'd1}, // R1 plain
        '{1'b1, AM, 64'd100,         AM, 64'd64,       4'd1}, // R1 saturate
        '{1'b1, AV, 64'd50,          AV, 64'd50,       4'd2}, // R2 under max
        '{1'b1, AM, 64'd20,          AV, 64'd50,       4'd6}, // R6 act kept
        '{1'b1, AV, 64'd30,          AV, 64'd20,       4'd2}, // R2 clamp
        '{1'b1, AP, 64'h1C20C9,      AP, 64'hC2243,    4'd4}, // R3 R4 dst clamp
        '{1'b1, AP, 64'hFF01F524,    AP, 64'h4104,     4'd3}, // R3 act clamp, gaps ignored
        '{1'b1, AM, 64'd50,          AP, 64'h4C44,     4'd6}, // R6 offsets kept
        '{1'b1, AV, 64'd2,           AP, 64'h4C41,     4'd6}, // R6 offsets kept
        '{1'b1, 12'h4C3, 64'd7,      AM, 64'd50,       4'd9}, // R9 other address
        '{1'b0, AM, 64'd9,           12'h123, 64'd0,   4'd9}, // R9 unmapped read
        '{1'b1, AP, 64'h7DF7DF,      AP, 64'h7DF7DF,   4'd5}, // R5 all fields max
        '{1'b0, AM, 64'd5,           AM, 64'd32,       4'd9}  // R9 we low
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [63:0] rd_data;
    logic        len_err;
    int          nchk = 0;
    int          nbad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    vlcfg_regs uut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
                    .len_err(len_err));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a);
        rd_addr = a;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7 reset state
        rd(AM); check("R7 max", rd_data, 64'd1);
        rd(AV); check("R7 act", rd_data, 64'd1);
        rd(AP); check("R7 packed", rd_data, 64'd0);
        check("R7 err", {63'd0, len_err}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_addr = VECS[i].waddr; wr_data = VECS[i].wdata;
            @(negedge clk);
            wr_en = 1'b0;
            rd(VECS[i].raddr);
            check($sformatf("R%0d vec%0d", VECS[i].rq, i), rd_data, VECS[i].exp);
        end

        // R8 zero write to max length
        wr(AM, 64'd0);
        check("R8 err after zero max", {63'd0, len_err}, 64'd1);
        rd(AM); check("R8 max stored zero", rd_data, 64'd0);
        @(negedge clk); #1;
        check("R8 err one cycle", {63'd0, len_err}, 64'd0);
        // R8 zero write to active length
        wr(AV, 64'd0);
        check("R8 err after zero act", {63'd0, len_err}, 64'd1);
        rd(AV); check("R8 act stored zero", rd_data, 64'd0);
        wr(AM, 64'd10);
        check("R8 nonzero no err", {63'd0, len_err}, 64'd0);
        // R8 combined write of zero is not an error; R3 gives length 1
        wr(AP, 64'd0);
        check("R8 packed zero no err", {63'd0, len_err}, 64'd0);
        rd(AP); check("R3 packed zero", rd_data, 64'd0);
        rd(AM); check("R3 max one", rd_data, 64'd1);

        // R7 reset mid-run
        wr(AP, 64'h7DF7DF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        rd(AP); check("R7 packed after reset", rd_data, 64'd0);
        rd(AV); check("R7 act after reset", rd_data, 64'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule